// File: doc/BRIEF.md
# Left-Shift Register with Parallel Load

This block is a small word register that can take one of three actions on each rising clock edge: move its contents one place toward the most significant bit, capture a whole parallel word, or keep its value. During a move, a serial input bit fills the vacated least significant position. The bit that sits in the most significant position is always visible on a serial output, so it is the bit that leaves on the next move.

The controls have a fixed priority. A synchronous active-low reset comes first. The shift control comes next and overrides load. Load acts only when shift is low. When both controls are low the register holds. The block can work as a serial-to-parallel converter (feed bits in, read the word) or as a parallel-to-serial converter (load a word, shift it out from the top). The width is a parameter with a default of 4.

Top module: `shl_load_reg`

## Requirements
- R1: When rst_n is 0 at a rising edge, q becomes all zeros and ser_out becomes 0, whatever shift_en, load_en, ser_in and par_in are.
- R2: When rst_n is 1 and shift_en is 1 at a rising edge, q becomes {old q[W-2:0], ser_in}: bit i takes old bit i-1 and bit 0 takes ser_in.
- R3: When shift_en and load_en are both 1, the register shifts exactly as in R2 and par_in has no effect on q.
- R4: When rst_n is 1, shift_en is 0 and load_en is 1 at a rising edge, q becomes par_in.
- R5: When rst_n is 1 and shift_en and load_en are both 0 at a rising edge, q keeps its value and ser_in and par_in have no effect.
- R6: ser_out always equals q[W-1], so after a shift ser_out shows the old q[W-2].
- R7: W consecutive shifts with ser_in = b0, b1, ..., b(W-1) leave q[W-1] = b0 and q[0] = b(W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear, highest priority |
| shift_en | input | 1 | Shift-left request, overrides load_en |
| load_en | input | 1 | Parallel capture request, acts only when shift_en is 0 |
| ser_in | input | 1 | Bit that enters q[0] during a shift |
| par_in | input | W | Parallel word captured during a load |
| q | output | W | Register contents |
| ser_out | output | 1 | Current MSB, the bit that leaves on the next shift |

## Verification
The bench applies every combination of the two controls, each with par_in and ser_in values that differ from the word already held. This way a hold, a load and a shift each give a different result, and a mistaken priority shows up at once. Reset is applied with both controls high and a nonzero par_in, which shows that clear overrides everything. Walking serial streams (1011, then 0100) and loading all-ones and alternating words show whether bit order and per-bit wiring are correct. A load followed by shifts with ser_in held at 0 shows that the parallel word leaves at ser_out with the MSB first.

// File: rtl/shl_load_pkg.sv
// Package: types shared by the left-shift register and its submodules.
// Assumes: nothing beyond IEEE 1800-2017.
package shl_load_pkg;

    // Action taken by every bit cell at the next rising edge.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_SHIFT = 2'd2,
        MODE_CLEAR = 2'd3
    } shl_mode_e;

endpackage

// File: rtl/shl_mode_dec.sv
// Module: shl_mode_dec
// Turns reset and the two controls into a single action code.
// Priority: clear, then shift, then load, then hold.
// Assumes: inputs are stable around the rising clock edge.
module shl_mode_dec
    import shl_load_pkg::*;
(
    input  logic      rst_n,
    input  logic      shift_en,
    input  logic      load_en,
    output shl_mode_e mode_o
);

    // Priority decode of the action for this cycle.
    always_comb begin
        if (!rst_n)
            mode_o = MODE_CLEAR;
        else if (shift_en)
            mode_o = MODE_SHIFT;
        else if (load_en)
            mode_o = MODE_LOAD;
        else
            mode_o = MODE_HOLD;
    end

    // Check that a shift request outside reset is never lost to load (R3).
    always_comb begin
        p_shift_wins_r3: assert (!(rst_n && shift_en) || mode_o == MODE_SHIFT);
    end

endmodule

// File: rtl/shl_bit_cell.sv
// Module: shl_bit_cell
// One storage bit: a D flip-flop fed by a four-way selector.
// Assumes: the mode is decoded once and shared by all cells.
module shl_bit_cell
    import shl_load_pkg::*;
(
    input  logic      clk,
    input  shl_mode_e mode_i,
    input  logic      par_i,
    input  logic      shin_i,
    output logic      q_o
);

    logic d_next;

    // Select the next value of this bit.
    always_comb begin
        case (mode_i)
            MODE_CLEAR: d_next = 1'b0;
            MODE_SHIFT: d_next = shin_i;
            MODE_LOAD:  d_next = par_i;
            default:    d_next = q_o;
        endcase
    end

    // Store the selected value on the rising edge.
    always_ff @(posedge clk) begin
        q_o <= d_next;
    end

endmodule

// File: rtl/shl_load_reg.sv
// Module: shl_load_reg (top)
// W-bit register with shift-left, parallel load and hold. The reset is
// synchronous and active low. Shift has priority over load.
// Assumes: W >= 2; all inputs synchronous to clk.
module shl_load_reg
    import shl_load_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         load_en,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q,
    output logic         ser_out
);

    localparam int MSB = W - 1;

    shl_mode_e mode;

    shl_mode_dec u_dec (
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .load_en  (load_en),
        .mode_o   (mode)
    );

    // One cell per bit. Bit 0 takes the serial input, the others take their lower neighbour.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic shin;
        if (i == 0) begin : g_lsb
            assign shin = ser_in;
        end else begin : g_mid
            assign shin = q[i-1];
        end
        shl_bit_cell u_cell (
            .clk    (clk),
            .mode_i (mode),
            .par_i  (par_in[i]),
            .shin_i (shin),
            .q_o    (q[i])
        );
    end

    // The MSB is the bit that leaves on the next shift.
    assign ser_out = q[MSB];

    // Reset clears the register whatever the controls are.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // Shift moves every bit up and takes ser_in into bit 0.
    p_shift_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (q == {$past(q[MSB-1:0]), $past(ser_in)}));

    // Load takes effect only while shift is low.
    p_load_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && load_en) |=> (q == $past(par_in)));

    // With both controls low the register keeps its value.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(q));

    // After a shift, the serial output shows the old next-to-top bit.
    p_ser_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (ser_out == $past(q[MSB-1])));

endmodule

// File: tb/shl_load_reg_tb_top.sv
// Scoreboard bench for shl_load_reg. A driver task applies one cycle of
// stimulus and pushes the expected result. A monitor pops and compares it.
module shl_load_reg_tb_top;

    localparam int W = 4;

    typedef struct {
        logic [W-1:0] exp_q;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0;
    logic         load_en = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q;
    logic         ser_out;

    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;
    logic [W-1:0] model = '0;
    exp_t         sb[$];

    always #4 clk = ~clk;

    shl_load_reg #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load_en(load_en),
        .ser_in(ser_in), .par_in(par_in), .q(q), .ser_out(ser_out)
    );

    // Driver: one clock of stimulus, expected value built from the requirements.
    task automatic step(input logic rn, input logic sh, input logic ld,
                        input logic si, input logic [W-1:0] pw, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rn; shift_en = sh; load_en = ld; ser_in = si; par_in = pw;
        @(posedge clk);
        if (!rn)      model = '0;
        else if (sh)  model = {model[W-2:0], si};
        else if (ld)  model = pw;
        e.exp_q = model;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare q and ser_out one half-period after each edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (q !== e.exp_q || ser_out !== e.exp_q[W-1]) begin
                errors++;
                $display("FAIL %s: q=%b ser_out=%b expected q=%b ser_out=%b",
                         e.tag, q, ser_out, e.exp_q, e.exp_q[W-1]);
            end
        end
    end

    initial begin
        step(1'b0, 1'b1, 1'b1, 1'b1, 4'b1111, "R1 reset with both controls high");
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'b1010, "R4 load 1010");
        step(1'b1, 1'b0, 1'b0, 1'b1, 4'b0101, "R5 hold ignores ser_in/par_in");
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'b0000, "R2 shift in 1");
        step(1'b1, 1'b1, 1'b1, 1'b0, 4'b1111, "R3 shift beats load");
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, "R6 ser_out after shift");
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'b1111, "R4 load all ones");
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, "R5 hold all ones");
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'b1111, "R1 reset clears");
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'b0000, "R7 stream bit 1");
        step(1'b1, 1'b1, 1'b1, 1'b0, 4'b0110, "R7 stream bit 0 (R3 load high)");
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'b0000, "R7 stream bit 1");
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'b0000, "R7 stream word 1011");
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, "R7 stream bit 0");
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'b0000, "R7 stream bit 1");
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, "R7 stream bit 0");
        step(1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, "R7 stream word 0100");
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'b0110, "R4 load 0110");
        for (int k = 0; k < W; k++)
            step(1'b1, 1'b1, 1'b0, 1'b0, 4'b1001, "R6 parallel word leaves MSB first");
        step(1'b1, 1'b0, 1'b0, 1'b1, 4'b1111, "R5 hold at zero");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R1-flow: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule